// File: doc/BRIEF.md
# Code Block Slot Boundary Decoder

This block takes one 256-bit code block, split into sixteen 16-bit slots, and tells the front end how the block is laid out. For each slot it reports whether the slot is part of the basic portion of an instruction. It also reports whether an instruction begins or ends in the slot, and whether the slot is header, data (a non-basic portion or unused), or the trailing map slot. It also reports the block format, the number of header slots and a malformed-block flag. All slots are resolved at once from the trailing slot's map field and from each slot's leading continuation bit. No step waits on a length decode of an earlier slot.

Slot 0 occupies block bits 255:240 and slot 15 occupies bits 15:0. Within a slot, the most significant bit is its leading (continuation) bit. An optional output register, selected by the parameter `REG_OUT` (default 1), captures a result only when `in_valid` is high.

Top module: `slot_block_decoder`

## Requirements
- R1: When the leading bit of slot 15 (block bit 15) is 0, `fmt` is 0 (dense), every bit of `basic_mask` is 1, and `hdr_mask` and `hdr_count` are 0.
- R2: When block bit 15 is 1, slot 15 is the map slot and is not basic. For slot i in 0..14, `basic_mask[i]` equals block bit 14-i. Every mask bit i refers to slot i.
- R3: When block bits 15:14 are `11`, `fmt` is 1 and there is no header. When they are `10`, `fmt` is 2. In that case `hdr_count` is the length of the run of 0 map bits that starts at slot 0, and `hdr_mask` marks exactly those slots.
- R4: `start_mask[i]` is 1 when slot i is basic and either no earlier slot is basic or the nearest earlier basic slot has its leading bit at 0.
- R5: `end_mask[i]` is 1 when slot i is basic and its leading bit is 0.
- R6: `slot_kinds[2i+1:2i]` gives the kind of slot i: 0 basic, 1 header, 2 data, 3 map.
- R7: `malformed` is 1 when some non-basic slot, the map slot included, has a nearest earlier basic slot whose leading bit is 1.
- R8: With `REG_OUT`=1, a reset clears `out_valid` and all result outputs to 0. A block presented with `in_valid` high appears on the outputs after the next clock edge, with `out_valid` high. While `in_valid` is low, `out_valid` is 0 and the result outputs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block word is present |
| block_in | input | 256 | Code block, slot 0 in the top 16 bits |
| out_valid | output | 1 | Result outputs hold a fresh decode |
| basic_mask | output | 16 | Slot is part of a basic portion |
| start_mask | output | 16 | An instruction starts in the slot |
| end_mask | output | 16 | A basic portion ends in the slot |
| hdr_mask | output | 16 | Slot is a header slot |
| hdr_count | output | 4 | Number of header slots |
| fmt | output | 2 | 0 dense, 1 mapped, 2 mapped with header |
| malformed | output | 1 | A basic portion runs into a non-basic slot |
| slot_kinds | output | 32 | Two-bit kind code for each slot |

## Verification
The hardest case to reach is the start decision for a basic slot that follows a gap of data slots. The answer depends on the leading bit of a basic slot that can sit several positions back. A related hard case is the malformed flag, which needs a continuation bit still open right before the map slot. To reach both, the stimulus sweeps every possible map slot value while the other slots carry a varying pseudo-random pattern of leading bits. A second sweep walks all combinations of leading bits for slots 0 to 14 in dense format.

// File: rtl/slotdec_pkg.sv
package slotdec_pkg;

    localparam int SLOTS   = 16;
    localparam int SLOT_W  = 16;
    localparam int BLOCK_W = SLOTS * SLOT_W;
    localparam int MAP_W   = SLOTS - 1;
    localparam int CNT_W   = $clog2(SLOTS);
    localparam int KIND_W  = 2;

    typedef enum logic [1:0] {
        FMT_DENSE  = 2'd0,
        FMT_MAPPED = 2'd1,
        FMT_HEADED = 2'd2,
        FMT_RSVD   = 2'd3
    } blk_fmt_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_BASIC  = 2'd0,
        KIND_HEADER = 2'd1,
        KIND_DATA   = 2'd2,
        KIND_MAP    = 2'd3
    } slot_kind_e;

    typedef logic [SLOTS-1:0] slot_mask_t;

    typedef struct packed {
        blk_fmt_e           fmt;
        slot_mask_t         basic;
        slot_mask_t         hdr;
        logic [CNT_W-1:0]   hdr_cnt;
    } layout_t;

    typedef struct packed {
        slot_mask_t start;
        slot_mask_t fin;
        logic       bad;
    } bound_t;

    typedef struct packed {
        layout_t                  lay;
        bound_t                   bnd;
        logic [KIND_W*SLOTS-1:0]  kinds;
    } decode_t;

    // Leading bit of the nearest basic slot below position idx (0 if none).
    function automatic logic open_before(slot_mask_t basic, slot_mask_t leads, int idx);
        logic o;
        o = 1'b0;
        for (int j = 0; j < SLOTS; j++) begin
            if (j < idx && basic[j]) begin
                o = leads[j];
            end
        end
        return o;
    endfunction

    function automatic logic [CNT_W-1:0] mask_pop(slot_mask_t m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int j = 0; j < SLOTS; j++) begin
            n = n + CNT_W'(m[j]);
        end
        return n;
    endfunction

endpackage

// File: rtl/slot_layout_decode.sv
module slot_layout_decode
    import slotdec_pkg::*;
(
    input  logic [BLOCK_W-1:0] block_i,
    output slot_mask_t         leads_o,
    output layout_t            lay_o
);
    logic [MAP_W-1:0] map_field;
    logic [MAP_W-1:0] zero_run;
    logic             mapped;
    slot_mask_t       basic;
    slot_mask_t       hdr;

    assign map_field = block_i[MAP_W-1:0];

    for (genvar g = 0; g < SLOTS; g++) begin : g_lead
        assign leads_o[g] = block_i[BLOCK_W-1-g*SLOT_W];
    end

    assign mapped = leads_o[SLOTS-1];

    for (genvar g = 0; g < MAP_W; g++) begin : g_map
        assign zero_run[g] = ~|map_field[MAP_W-1 -: g+1];
        assign basic[g]    = mapped ? map_field[MAP_W-1-g] : 1'b1;
        assign hdr[g]      = mapped & zero_run[g];
    end

    assign basic[SLOTS-1] = ~mapped;
    assign hdr[SLOTS-1]   = 1'b0;

    always_comb begin
        lay_o.basic   = basic;
        lay_o.hdr     = hdr;
        lay_o.hdr_cnt = mask_pop(hdr);
        if (!mapped) begin
            lay_o.fmt = FMT_DENSE;
        end else if (map_field[MAP_W-1]) begin
            lay_o.fmt = FMT_MAPPED;
        end else begin
            lay_o.fmt = FMT_HEADED;
        end
    end
endmodule

// File: rtl/slot_boundary_mark.sv
module slot_boundary_mark
    import slotdec_pkg::*;
(
    input  slot_mask_t basic_i,
    input  slot_mask_t leads_i,
    output bound_t     bnd_o
);
    slot_mask_t open;

    for (genvar g = 0; g < SLOTS; g++) begin : g_open
        assign open[g]          = open_before(basic_i, leads_i, g);
        assign bnd_o.start[g]   = basic_i[g] & ~open[g];
        assign bnd_o.fin[g]     = basic_i[g] & ~leads_i[g];
    end

    assign bnd_o.bad = |(~basic_i & open);
endmodule

// File: rtl/slot_kind_encode.sv
module slot_kind_encode
    import slotdec_pkg::*;
(
    input  layout_t                  lay_i,
    output logic [KIND_W*SLOTS-1:0]  kinds_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_kind
        slot_kind_e k;
        always_comb begin
            if (g == SLOTS-1 && lay_i.fmt != FMT_DENSE) begin
                k = KIND_MAP;
            end else if (lay_i.basic[g]) begin
                k = KIND_BASIC;
            end else if (lay_i.hdr[g]) begin
                k = KIND_HEADER;
            end else begin
                k = KIND_DATA;
            end
        end
        assign kinds_o[KIND_W*g +: KIND_W] = k;
    end
endmodule

// File: rtl/slot_block_decoder.sv
module slot_block_decoder
    import slotdec_pkg::*;
#(
    parameter int REG_OUT = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [BLOCK_W-1:0]      block_in,
    output logic                    out_valid,
    output logic [SLOTS-1:0]        basic_mask,
    output logic [SLOTS-1:0]        start_mask,
    output logic [SLOTS-1:0]        end_mask,
    output logic [SLOTS-1:0]        hdr_mask,
    output logic [CNT_W-1:0]        hdr_count,
    output logic [1:0]              fmt,
    output logic                    malformed,
    output logic [KIND_W*SLOTS-1:0] slot_kinds
);
    slot_mask_t leads;
    decode_t    nxt;
    decode_t    cur;

    slot_layout_decode u_layout (
        .block_i (block_in),
        .leads_o (leads),
        .lay_o   (nxt.lay)
    );

    slot_boundary_mark u_bound (
        .basic_i (nxt.lay.basic),
        .leads_i (leads),
        .bnd_o   (nxt.bnd)
    );

    slot_kind_encode u_kind (
        .lay_i   (nxt.lay),
        .kinds_o (nxt.kinds)
    );

    if (REG_OUT != 0) begin : g_reg
        decode_t q;
        logic    vq;
        always_ff @(posedge clk) begin
            if (rst) begin
                q  <= '0;
                vq <= 1'b0;
            end else begin
                vq <= in_valid;
                if (in_valid) begin
                    q <= nxt;
                end
            end
        end
        assign cur       = q;
        assign out_valid = vq;
    end else begin : g_comb
        assign cur       = nxt;
        assign out_valid = in_valid;
    end

    assign basic_mask = cur.lay.basic;
    assign hdr_mask   = cur.lay.hdr;
    assign hdr_count  = cur.lay.hdr_cnt;
    assign fmt        = cur.lay.fmt;
    assign start_mask = cur.bnd.start;
    assign end_mask   = cur.bnd.fin;
    assign malformed  = cur.bnd.bad;
    assign slot_kinds = cur.kinds;
endmodule

// File: rtl/slot_block_decoder_chk.sv
module slot_block_decoder_chk #(
    parameter int REG_OUT = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic [15:0] basic_mask,
    input logic [15:0] start_mask,
    input logic [15:0] end_mask,
    input logic [15:0] hdr_mask,
    input logic [3:0]  hdr_count,
    input logic [1:0]  fmt,
    input logic        malformed,
    input logic [31:0] slot_kinds
);
    assert_dense_all_basic_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && fmt == 2'd0) |-> (basic_mask == 16'hFFFF && hdr_mask == 16'd0));

    assert_map_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && fmt != 2'd0) |-> (!basic_mask[15] && slot_kinds[31:30] == 2'd3));

    assert_hdr_contiguous_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((hdr_mask & (hdr_mask + 16'd1)) == 16'd0));

    assert_hdr_fmt_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((fmt == 2'd2) == (hdr_count != 4'd0)));

    assert_start_in_basic_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((start_mask & ~basic_mask) == 16'd0));

    assert_end_in_basic_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((end_mask & ~basic_mask) == 16'd0));

    assert_hdr_not_basic_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((hdr_mask & basic_mask) == 16'd0));

    assert_balanced_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !malformed) |-> ($countones(start_mask) == $countones(end_mask)));

    if (REG_OUT != 0) begin : g_lat
        assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
    end
endmodule

bind slot_block_decoder slot_block_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .basic_mask (basic_mask),
    .start_mask (start_mask),
    .end_mask   (end_mask),
    .hdr_mask   (hdr_mask),
    .hdr_count  (hdr_count),
    .fmt        (fmt),
    .malformed  (malformed),
    .slot_kinds (slot_kinds)
);

// File: tb/slot_block_decoder_bench.sv
`timescale 1ns/100ps
module slot_block_decoder_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] block_in = '0;
    logic         out_valid;
    logic [15:0]  basic_mask, start_mask, end_mask, hdr_mask;
    logic [3:0]   hdr_count;
    logic [1:0]   fmt;
    logic         malformed;
    logic [31:0]  slot_kinds;

    int checks = 0;
    int errors = 0;

    logic [15:0] e_basic, e_start, e_end, e_hdr;
    logic [3:0]  e_cnt;
    logic [1:0]  e_fmt;
    logic        e_bad;
    logic [31:0] e_kinds;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    slot_block_decoder #(.REG_OUT(1)) u_slot_block_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .block_in(block_in),
        .out_valid(out_valid), .basic_mask(basic_mask), .start_mask(start_mask),
        .end_mask(end_mask), .hdr_mask(hdr_mask), .hdr_count(hdr_count),
        .fmt(fmt), .malformed(malformed), .slot_kinds(slot_kinds)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Sequential reference model, walking the slots one by one.
    task automatic model(input logic [255:0] b);
        logic lead15, open, zeros;
        lead15 = b[15];
        e_hdr = '0; e_cnt = '0; e_start = '0; e_end = '0; e_bad = 1'b0; e_kinds = '0;
        if (!lead15) begin
            e_fmt = 2'd0;
            e_basic = 16'hFFFF;
        end else begin
            e_fmt = b[14] ? 2'd1 : 2'd2;
            e_basic = '0;
            for (int i = 0; i < 15; i++) e_basic[i] = b[14-i];
            zeros = 1'b1;
            for (int i = 0; i < 15; i++) begin
                if (b[14-i]) zeros = 1'b0;
                if (zeros) begin
                    e_hdr[i] = 1'b1;
                    e_cnt = e_cnt + 4'd1;
                end
            end
        end
        open = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (e_basic[i]) begin
                e_start[i] = !open;
                e_end[i] = !b[255-16*i];
                open = b[255-16*i];
                e_kinds[2*i +: 2] = 2'd0;
            end else begin
                if (open) e_bad = 1'b1;
                if (i == 15) e_kinds[2*i +: 2] = 2'd3;
                else if (e_hdr[i]) e_kinds[2*i +: 2] = 2'd1;
                else e_kinds[2*i +: 2] = 2'd2;
            end
        end
    endtask

    task automatic compare_all();
        check(out_valid === 1'b1, "R8 out_valid", 64'(out_valid), 64'd1);
        check(fmt === e_fmt, "R1/R3 fmt", 64'(fmt), 64'(e_fmt));
        check(basic_mask === e_basic, "R1/R2 basic_mask", 64'(basic_mask), 64'(e_basic));
        check(hdr_mask === e_hdr && hdr_count === e_cnt, "R3 header",
              {44'd0, hdr_count, hdr_mask}, {44'd0, e_cnt, e_hdr});
        check(start_mask === e_start, "R4 start_mask", 64'(start_mask), 64'(e_start));
        check(end_mask === e_end, "R5 end_mask", 64'(end_mask), 64'(e_end));
        check(slot_kinds === e_kinds, "R6 slot_kinds", 64'(slot_kinds), 64'(e_kinds));
        check(malformed === e_bad, "R7 malformed", 64'(malformed), 64'(e_bad));
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic apply(input logic [255:0] b);
        @(negedge clk);
        block_in = b;
        in_valid = 1'b1;
        model(b);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] b;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check(out_valid === 1'b0, "R8 reset out_valid", 64'(out_valid), 64'd0);
        check({basic_mask, start_mask, end_mask, hdr_mask} === 64'd0, "R8 reset masks",
              {basic_mask, start_mask, end_mask, hdr_mask}, 64'd0);
        check({hdr_count, fmt, malformed, slot_kinds} === 39'd0, "R8 reset misc",
              64'({hdr_count, fmt, malformed, slot_kinds}), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // Sweep every map slot value; body slots from a pseudo-random pattern (R1..R7).
        for (int v = 0; v < 65536; v++) begin
            for (int s = 0; s < 15; s++) begin
                lfsr = step(lfsr);
                b[255-16*s -: 16] = lfsr[15:0];
            end
            b[15:0] = 16'(v);
            apply(b);
        end

        // Sweep all leading-bit combinations in dense format (R1, R4, R5, R7).
        for (int p = 0; p < 32768; p++) begin
            for (int s = 0; s < 15; s++) begin
                lfsr = step(lfsr);
                b[255-16*s -: 16] = {p[s], lfsr[14:0]};
            end
            lfsr = step(lfsr);
            b[15:0] = {1'b0, lfsr[14:0]};
            apply(b);
        end

        // R8: hold while in_valid is low.
        b = {16{16'h8000}};
        b[15:0] = 16'hA5A5;
        apply(b);
        @(negedge clk);
        in_valid = 1'b0;
        block_in = '0;
        @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R8 idle out_valid", 64'(out_valid), 64'd0);
        check(basic_mask === e_basic && start_mask === e_start, "R8 hold masks",
              {32'd0, basic_mask, start_mask}, {32'd0, e_basic, e_start});
        check(slot_kinds === e_kinds, "R8 hold kinds", 64'(slot_kinds), 64'(e_kinds));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule